// File: doc/BRIEF.md
# Write-Completion Acknowledge-Polling Sequencer

This block sits on the master side of a two-wire serial bus and commits single-byte writes to a serial EEPROM. Each request carries a 16-bit memory address and one data byte. The block drives a byte-level bus master and never waits a fixed worst-case programming time. Once the write has been closed with STOP, the memory stops answering while it programs its cells. The block therefore probes it again and again with START followed by the device select byte. The first probe that is acknowledged marks the end of programming.

An acknowledged probe also opens the next command, because the memory now expects the rest of an instruction. If another request is already waiting, the block accepts it in that cycle and sends its address bytes straight away, without another START or select byte. If no request is waiting, the block closes the bus with STOP. A bounded probe count ends a memory that never answers with a STOP and a timeout pulse. A NACK on any byte of the write itself ends the transfer with an error pulse.

Requests arrive on a valid/ready port. The requester holds `req_valid`, `req_addr` and `req_data` steady until `req_ready` is high at a clock edge. Commands leave on a valid/ready port. The controller holds `cmd_valid`, `cmd_op` and `cmd_byte` steady until `cmd_ready` is high. The byte master answers each accepted command with exactly one `rsp_valid` pulse, and it may hold that answer back for any number of cycles. Only one command is outstanding at a time.

Top module: `eeprom_ackpoll_seq`

## Requirements
- R1: A request produces, in order, START (cmd_op 0), WRITE (cmd_op 1) of the select byte {DEV_ADDR, 0}, WRITE of address bits 15:8, WRITE of address bits 7:0, WRITE of the data byte, and STOP (cmd_op 2).
- R2: Probing starts only after the STOP that closes the write has been answered, and each probe is START followed by WRITE of the select byte.
- R3: A NACK on a probe select byte is followed by another START and select byte, as long as fewer than MAX_POLLS probes have been made.
- R4: An acknowledged probe raises `done` for exactly one cycle, in the cycle after its response. At that point `poll_count` equals the number of probes made for this write, including the successful one.
- R5: If no request is valid in the cycle of the acknowledged probe, the next command is STOP and the block then returns to idle.
- R6: If a request is valid in the cycle of the acknowledged probe, `req_ready` is high in that same cycle. The next command is then WRITE of the new address high byte, with no START and no repeated select byte.
- R7: When the MAX_POLLS-th probe is NACKed, `err_timeout` pulses for one cycle, `poll_count` equals MAX_POLLS, `done` does not pulse, and the next command is STOP.
- R8: A NACK on any of the four write bytes pulses `err_nack`, and the next command is STOP. No probing and no `done` follow.
- R9: `cmd_op` and `cmd_byte` stay stable while `cmd_valid` is high and `cmd_ready` is low, and no new command is offered until the previous command has been answered. `req_ready` is low while a transfer is in progress, except in the cycle of an acknowledged probe.
- R10: After reset the block is idle with `req_ready` high, `cmd_valid` low, `done`, `err_nack` and `err_timeout` low, and `poll_count` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request offered |
| req_ready | output | 1 | Write request taken this cycle |
| req_addr | input | 16 | Memory address of the write |
| req_data | input | 8 | Byte to write |
| cmd_valid | output | 1 | Bus command offered |
| cmd_ready | input | 1 | Bus master takes the command |
| cmd_op | output | 2 | 0 START, 1 WRITE byte, 2 STOP |
| cmd_byte | output | 8 | Byte for a WRITE command |
| rsp_valid | input | 1 | One pulse per accepted command |
| rsp_nack | input | 1 | The written byte was not acknowledged (meaningful with rsp_valid) |
| done | output | 1 | One-cycle pulse: write finished programming |
| err_nack | output | 1 | One-cycle pulse: a write byte was refused |
| err_timeout | output | 1 | One-cycle pulse: probe limit reached |
| poll_count | output | CNT_W | Probes made for the latest write |

## Verification
Two functions can coincide in a single cycle. One is the acknowledged probe that completes one write. The other is the acceptance of the next request. The bench creates this overlap by presenting requests back to back while the memory model stays busy for a random number of probes, so the following request is already waiting when the probe is finally acknowledged. The bench then confirms three things: `req_ready` is high in the cycle of the acknowledging response, `done` reports the earlier write with its own probe count, and the next command is the address high byte rather than START or STOP. When no request is waiting in that cycle, the next command must be STOP instead.

// File: rtl/ackpoll_pkg.sv
package ackpoll_pkg;
  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_WRITE = 2'd1,
    OP_STOP  = 2'd2
  } bus_op_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_W_START,
    S_W_SEL,
    S_W_AHI,
    S_W_ALO,
    S_W_DAT,
    S_W_STOP,
    S_P_START,
    S_P_SEL,
    S_END_STOP,
    S_ERR_STOP
  } seq_state_e;
endpackage

// File: rtl/ackpoll_cmd_port.sv
module ackpoll_cmd_port (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic cmd_ready,
  input  logic rsp_valid,
  output logic cmd_valid,
  output logic step
);
  logic waiting;

  // One command in flight: offered, taken, then answered.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      waiting <= 1'b0;
    end else if (cmd_valid && cmd_ready) begin
      waiting <= 1'b1;
    end else if (rsp_valid && waiting) begin
      waiting <= 1'b0;
    end
  end

  assign cmd_valid = active && !waiting;
  assign step      = rsp_valid && waiting;
endmodule

// File: rtl/ackpoll_poll_ctr.sv
module ackpoll_poll_ctr #(
  parameter int MAX_POLLS = 64,
  parameter int CNT_W     = $clog2(MAX_POLLS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count,
  output logic             last
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(MAX_POLLS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (clr) begin
      count <= '0;
    end else if (inc) begin
      count <= count + 1'b1;
    end
  end

  // The attempt now in flight is the final one allowed.
  assign last = (count >= LAST_IDX);
endmodule

// File: rtl/eeprom_ackpoll_seq.sv
module eeprom_ackpoll_seq #(
  parameter logic [6:0] DEV_ADDR  = 7'h50,
  parameter int         MAX_POLLS = 64,
  parameter int         CNT_W     = $clog2(MAX_POLLS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [15:0]      req_addr,
  input  logic [7:0]       req_data,
  output logic             cmd_valid,
  input  logic             cmd_ready,
  output logic [1:0]       cmd_op,
  output logic [7:0]       cmd_byte,
  input  logic             rsp_valid,
  input  logic             rsp_nack,
  output logic             done,
  output logic             err_nack,
  output logic             err_timeout,
  output logic [CNT_W-1:0] poll_count
);
  import ackpoll_pkg::*;

  localparam logic [7:0] SEL_WR = {DEV_ADDR, 1'b0};

  seq_state_e state, nxt;
  logic [15:0] addr_q;
  logic [7:0]  data_q;
  logic        step, take, cnt_clr, cnt_inc, cnt_last;
  logic        done_d, nack_d, tmo_d;
  bus_op_e     op;
  logic [7:0]  obyte;

  ackpoll_cmd_port u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (state != S_IDLE),
    .cmd_ready (cmd_ready),
    .rsp_valid (rsp_valid),
    .cmd_valid (cmd_valid),
    .step      (step)
  );

  ackpoll_poll_ctr #(.MAX_POLLS(MAX_POLLS), .CNT_W(CNT_W)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .inc   (cnt_inc),
    .count (poll_count),
    .last  (cnt_last)
  );

  always_comb begin
    nxt     = state;
    op      = OP_WRITE;
    obyte   = 8'h00;
    take    = 1'b0;
    cnt_clr = 1'b0;
    cnt_inc = 1'b0;
    done_d  = 1'b0;
    nack_d  = 1'b0;
    tmo_d   = 1'b0;
    unique case (state)
      S_IDLE: begin
        take = req_valid;
        if (req_valid) nxt = S_W_START;
      end
      S_W_START, S_P_START: begin
        op = OP_START;
        if (step) nxt = (state == S_W_START) ? S_W_SEL : S_P_SEL;
      end
      S_W_SEL, S_W_AHI, S_W_ALO, S_W_DAT: begin
        case (state)
          S_W_SEL: obyte = SEL_WR;
          S_W_AHI: obyte = addr_q[15:8];
          S_W_ALO: obyte = addr_q[7:0];
          default: obyte = data_q;
        endcase
        if (step) begin
          nack_d = rsp_nack;
          if (rsp_nack)               nxt = S_ERR_STOP;
          else if (state == S_W_SEL)  nxt = S_W_AHI;
          else if (state == S_W_AHI)  nxt = S_W_ALO;
          else if (state == S_W_ALO)  nxt = S_W_DAT;
          else                        nxt = S_W_STOP;
        end
      end
      S_W_STOP: begin
        op = OP_STOP;
        if (step) begin
          cnt_clr = 1'b1;
          nxt     = S_P_START;
        end
      end
      S_P_SEL: begin
        obyte = SEL_WR;
        if (step) begin
          cnt_inc = 1'b1;
          if (!rsp_nack) begin
            done_d = 1'b1;
            take   = req_valid;
            nxt    = req_valid ? S_W_AHI : S_END_STOP;
          end else if (cnt_last) begin
            tmo_d = 1'b1;
            nxt   = S_ERR_STOP;
          end else begin
            nxt = S_P_START;
          end
        end
      end
      S_END_STOP, S_ERR_STOP: begin
        op = OP_STOP;
        if (step) nxt = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end

  assign req_ready = (state == S_IDLE) ||
                     ((state == S_P_SEL) && step && !rsp_nack);
  assign cmd_op    = op;
  assign cmd_byte  = obyte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      addr_q      <= '0;
      data_q      <= '0;
      done        <= 1'b0;
      err_nack    <= 1'b0;
      err_timeout <= 1'b0;
    end else begin
      state       <= nxt;
      done        <= done_d;
      err_nack    <= nack_d;
      err_timeout <= tmo_d;
      if (take) begin
        addr_q <= req_addr;
        data_q <= req_data;
      end
    end
  end
endmodule

// File: rtl/ackpoll_chk.sv
module ackpoll_chk #(
  parameter int MAX_POLLS = 64,
  parameter int CNT_W     = $clog2(MAX_POLLS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [1:0]       cmd_op,
  input logic [7:0]       cmd_byte,
  input logic             done,
  input logic             err_nack,
  input logic             err_timeout,
  input logic [CNT_W-1:0] poll_count
);
  // R9: an offered command holds still until taken
  p_cmd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) && $stable(cmd_byte));

  // R9: nothing new is offered right after a command is taken
  p_one_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> !cmd_valid);

  // R4: completion lasts one cycle
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: timeout and completion never coincide
  p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err_timeout));

  // R7: probe count stays within its bound
  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    poll_count <= CNT_W'(MAX_POLLS));

  // R7: timeout is followed by a STOP offer
  p_tmo_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_timeout |-> cmd_valid && cmd_op == 2'd2);

  // R8: a refused write byte is followed by a STOP offer
  p_nack_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_nack |-> cmd_valid && cmd_op == 2'd2);
endmodule

bind eeprom_ackpoll_seq ackpoll_chk #(.MAX_POLLS(MAX_POLLS), .CNT_W(CNT_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_valid   (cmd_valid),
  .cmd_ready   (cmd_ready),
  .cmd_op      (cmd_op),
  .cmd_byte    (cmd_byte),
  .done        (done),
  .err_nack    (err_nack),
  .err_timeout (err_timeout),
  .poll_count  (poll_count)
);

// File: tb/eeprom_ackpoll_seq_tb_top.sv
`timescale 1ns/1ps
module eeprom_ackpoll_seq_tb_top;
  localparam int         MAXP = 6;
  localparam int         CW   = $clog2(MAXP + 1);
  localparam logic [6:0] DEV  = 7'h50;
  localparam logic [7:0] SELW = {DEV, 1'b0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [15:0] req_addr = '0;
  logic [7:0] req_data = '0;
  logic cmd_valid;
  logic cmd_ready = 1'b0;
  logic [1:0] cmd_op;
  logic [7:0] cmd_byte;
  logic rsp_valid = 1'b0;
  logic rsp_nack = 1'b0;
  logic done, err_nack, err_timeout;
  logic [CW-1:0] poll_count;

  always #2.5 clk = ~clk;

  eeprom_ackpoll_seq #(.DEV_ADDR(DEV), .MAX_POLLS(MAXP)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_byte(cmd_byte),
    .rsp_valid(rsp_valid), .rsp_nack(rsp_nack), .done(done),
    .err_nack(err_nack), .err_timeout(err_timeout), .poll_count(poll_count)
  );

  typedef struct {
    logic [15:0] addr;
    logic [7:0]  data;
    int          busy;
    int          inj;
  } job_t;

  job_t send_q[$];
  job_t exp_q[$];
  logic [7:0] mem [logic [15:0]];
  int checks = 0, errors = 0;
  bit finished = 0;

  // model state
  int byte_idx = 0, busy_left = 0;
  bit aborted = 0, hs_pend = 0, after_commit = 0, poll_mode = 0;
  bit poll_ack_now = 0, poll_ack_prev = 0, chain_exp = 0, stop_next = 0, req_acc = 0;
  bit done_prev = 0;
  logic [1:0] hs_op;
  logic [7:0] hs_byte;
  logic [15:0] cur_addr;
  logic [7:0] cur_data;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  function automatic int outcome(input job_t j);
    if (j.inj >= 0) return 2;
    if (j.busy >= MAXP) return 1;
    return 0;
  endfunction

  task automatic do_cmd(output bit nack);
    nack = 1'b0;
    case (hs_op)
      2'd0: begin
        chk(!poll_ack_prev, "R5 START after acked probe", 0, 1);
        chk(!stop_next, "R8 START instead of STOP after error", 0, 2);
        poll_ack_prev = 0;
        after_commit = 0;
        byte_idx = 0;
        aborted = 0;
      end
      2'd2: begin
        chk(!after_commit, "R2 STOP right after write", 2, 0);
        if (poll_ack_prev) begin
          chk(!chain_exp, "R5 STOP though request chained", 2, 1);
          poll_ack_prev = 0;
        end
        if (stop_next) begin
          chk(1'b1, "R8 STOP after error", 2, 2);
          stop_next = 0;
        end
        if (byte_idx == 4 && !aborted && exp_q.size() > 0) begin
          mem[cur_addr] = cur_data;
          busy_left = exp_q[0].busy;
          poll_mode = 1;
          after_commit = 1;
        end
        byte_idx = 0;
      end
      default: begin
        chk(!after_commit, "R2 write byte without START", 1, 0);
        if (poll_ack_prev) begin
          chk(chain_exp, "R6 write after acked probe", 1, 2);
          chk(byte_idx == 1, "R6 no repeated select", byte_idx, 1);
          poll_ack_prev = 0;
        end
        case (byte_idx)
          0: begin
            chk(hs_byte == SELW, "R1 select byte", hs_byte, SELW);
            if (poll_mode) begin
              if (busy_left > 0) begin
                busy_left--;
                nack = 1'b1;
              end else begin
                poll_mode = 0;
                poll_ack_now = 1;
              end
            end
          end
          1: begin
            if (exp_q.size() > 0)
              chk(hs_byte == exp_q[0].addr[15:8], "R1 address high", hs_byte, exp_q[0].addr[15:8]);
            cur_addr[15:8] = hs_byte;
          end
          2: begin
            if (exp_q.size() > 0)
              chk(hs_byte == exp_q[0].addr[7:0], "R1 address low", hs_byte, exp_q[0].addr[7:0]);
            cur_addr[7:0] = hs_byte;
          end
          3: begin
            if (exp_q.size() > 0)
              chk(hs_byte == exp_q[0].data, "R1 data byte", hs_byte, exp_q[0].data);
            cur_data = hs_byte;
          end
          default: chk(1'b0, "R1 extra write byte", byte_idx, 3);
        endcase
        if (!poll_mode && !poll_ack_now && exp_q.size() > 0 && exp_q[0].inj == byte_idx) begin
          nack = 1'b1;
          aborted = 1;
        end
        byte_idx++;
      end
    endcase
  endtask

  // Bus master / memory model and output monitor, all at the falling edge.
  initial begin
    bit nk;
    job_t j;
    wait (rst_n);
    forever begin
      @(negedge clk);
      rsp_valid = 1'b0;
      rsp_nack = 1'b0;
      if (hs_pend) begin
        do_cmd(nk);
        rsp_valid = 1'b1;
        rsp_nack = nk;
        hs_pend = 0;
      end
      if (req_acc) begin
        req_valid = 1'b0;
        req_acc = 0;
      end
      if (!req_valid && send_q.size() > 0) begin
        req_valid = 1'b1;
        req_addr = send_q[0].addr;
        req_data = send_q[0].data;
      end
      cmd_ready = ($urandom % 4) != 0;
      #1;
      if (done) begin
        chk(!done_prev, "R4 done one cycle", 1, 0);
        chk(!err_timeout, "R7 done with timeout", 1, 0);
        if (exp_q.size() > 0) begin
          j = exp_q.pop_front();
          chk(outcome(j) == 0, "R4 unexpected done", 0, outcome(j));
          chk(int'(poll_count) == j.busy + 1, "R4 poll_count", poll_count, j.busy + 1);
          chk(mem.exists(j.addr) && mem[j.addr] == j.data, "R1 stored byte",
              mem.exists(j.addr) ? mem[j.addr] : -1, j.data);
        end else chk(1'b0, "R4 done with nothing pending", 1, 0);
      end
      if (err_timeout) begin
        if (exp_q.size() > 0) begin
          j = exp_q.pop_front();
          chk(outcome(j) == 1, "R7 unexpected timeout", 1, outcome(j));
          chk(int'(poll_count) == MAXP, "R7 poll_count", poll_count, MAXP);
          chk(busy_left == j.busy - MAXP, "R3 probes before timeout", busy_left, j.busy - MAXP);
        end
        busy_left = 0;
        poll_mode = 0;
        stop_next = 1;
      end
      if (err_nack) begin
        if (exp_q.size() > 0) begin
          j = exp_q.pop_front();
          chk(outcome(j) == 2, "R8 unexpected nack error", 2, outcome(j));
        end
        stop_next = 1;
      end
      done_prev = done;
      if (poll_ack_now) begin
        if (req_valid) chk(req_ready, "R6 ready in probe-ack cycle", req_ready, 1);
        chain_exp = req_valid && req_ready;
        poll_ack_prev = 1;
        poll_ack_now = 0;
      end else if (req_valid && exp_q.size() > 0) begin
        chk(!req_ready, "R9 ready during transfer", req_ready, 0);
      end
      if (req_valid && req_ready) begin
        exp_q.push_back(send_q.pop_front());
        req_acc = 1;
      end
      if (cmd_valid && cmd_ready) begin
        hs_pend = 1;
        hs_op = cmd_op;
        hs_byte = cmd_byte;
      end
    end
  end

  task automatic add_job(input logic [15:0] a, input logic [7:0] d, input int b, input int inj);
    job_t j;
    j.addr = a; j.data = d; j.busy = b; j.inj = inj;
    send_q.push_back(j);
  endtask

  task automatic wait_idle();
    while (send_q.size() > 0 || exp_q.size() > 0) @(negedge clk);
    repeat (20) @(negedge clk);
  endtask

  initial begin
    int n;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    #1;
    chk(req_ready == 1'b1, "R10 req_ready after reset", req_ready, 1);
    chk(cmd_valid == 1'b0, "R10 cmd_valid after reset", cmd_valid, 0);
    chk(!done && !err_nack && !err_timeout, "R10 pulses low after reset", done, 0);
    chk(poll_count == '0, "R10 poll_count after reset", poll_count, 0);
    @(negedge clk);
    rst_n = 1'b1;

    add_job(16'h1234, 8'hA5, 0, -1);      wait_idle();  // R4 one probe
    add_job(16'hBEEF, 8'h3C, 3, -1);      wait_idle();  // R3 retries
    add_job(16'h0001, 8'h77, MAXP-1, -1); wait_idle();  // R4 last allowed probe
    add_job(16'h4000, 8'h11, MAXP, -1);   wait_idle();  // R7 timeout
    add_job(16'h2222, 8'h22, 0, 0);       wait_idle();  // R8 select refused
    add_job(16'h3333, 8'h33, 2, 2);       wait_idle();  // R8 low address refused
    add_job(16'h4444, 8'h44, 1, 3);       wait_idle();  // R8 data refused
    add_job(16'h5555, 8'h55, 1, 1);       wait_idle();  // R8 high address refused
    // R6 chained requests
    add_job(16'h6000, 8'h60, 2, -1);
    add_job(16'h6001, 8'h61, 0, -1);
    add_job(16'h6002, 8'h62, 4, -1);
    add_job(16'h6003, 8'h63, MAXP + 1, -1);
    add_job(16'h6004, 8'h64, 1, -1);
    wait_idle();

    for (int k = 0; k < 40; k++) begin
      n = ($urandom % 6 == 0) ? 1 + ($urandom % 3) : -1;
      add_job(16'($urandom), 8'($urandom), $urandom % (MAXP + 2), n);
      if ($urandom % 3 == 0) wait_idle();
    end
    wait_idle();
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not complete actual=%0d expected=%0d", 0, 1);
      finish_run();
    end
  end
endmodule